// File: doc/BRIEF.md
# Phase-Frequency Detector with Hysteretic Digital Lock Detect

This block compares two divided clocks inside a synthesizer loop: the reference-divider output and the feedback (N-divider) output. Whichever input shows a rising edge first drives its correction output (`up` when the reference leads, `dn` when the feedback leads) until the other edge arrives. Both outputs are then held high together for a short anti-backlash interval and released, so even a tiny phase difference produces a measurable correction pulse and the transfer function has no dead zone.

All logic runs on one fast sampling clock whose period is the parameter `SAMPLE_PS`. The time between the two edges of each detector cycle is counted in sampling ticks and handed to a lock detector. The lock and unlock thresholds and the anti-backlash delay are set in physical time (nanoseconds or picoseconds) and converted to ticks. The lock flag rises only after several consecutive good cycles (error under the tight threshold) and falls on a single cycle whose error exceeds the looser threshold. An error between the two thresholds leaves the flag as it is, which gives the flag hysteresis.

The detector state machine has four states: IDLE (waiting for an edge), LEAD (reference edge seen, `up` high), LAG (feedback edge seen, `dn` high) and BACKLASH (both outputs high for the reset delay). Its transitions are: IDLE to LEAD on a lone reference edge, IDLE to LAG on a lone feedback edge, IDLE to BACKLASH when both edges fall in the same sample, LEAD to BACKLASH on the feedback edge, LAG to BACKLASH on the reference edge, and BACKLASH to IDLE when the delay has run out. The lock state machine has two states: SEARCH (counting consecutive good cycles) and LOCKED. SEARCH goes to LOCKED when the required run of good cycles is reached. LOCKED goes back to SEARCH on a cycle whose error is above the unlock threshold.

Top module: `pd_lockdet_top`

## Requirements
- R1: During and after reset, with no input edges, `up`, `dn` and `locked` are 0.
- R2: When the reference rises d ≥ 1 samples before the feedback, `up` goes high in the sample after the reference edge is sampled. It stays high for d + ABL samples. `dn` goes high only at the feedback edge.
- R3: When the feedback rises d ≥ 1 samples before the reference, `dn` is high for d + ABL samples and `up` is high only for the final ABL samples.
- R4: After the later edge of a cycle, `up` and `dn` are both high for exactly ABL = ceil(ABL_PS/SAMPLE_PS) samples (3 by default). Then both are low. Neither output ever falls while the other is low.
- R5: Edges on both inputs in the same sample give `up` and `dn` high together for exactly ABL samples. The cycle is recorded as zero error and counts as good.
- R6: The phase error of a cycle is the edge separation d in samples. A cycle is good when d < LOCK_NS·1000/SAMPLE_PS (15 by default). `locked` rises one sample after the third consecutive good cycle completes, and not earlier.
- R7: A cycle with error from 15 to 25 inclusive (defaults) leaves `locked` unchanged and restarts the run of consecutive good cycles.
- R8: While locked, a single cycle with error > UNLOCK_NS·1000/SAMPLE_PS (25 by default) clears `locked`. Three new consecutive good cycles are then needed to set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock; sets the time resolution |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference-divider output; rising edges are compared |
| fb_in | input | 1 | Feedback-divider output; rising edges are compared |
| up | output | 1 | Correction pulse when the reference leads |
| dn | output | 1 | Correction pulse when the feedback leads |
| locked | output | 1 | Active-high digital lock flag |

## Verification
The bench sweeps the phase offset through lead, lag and coincident edges, and measures every `up`/`dn` pulse width against d + ABL. A wrong anti-backlash count or a tick lost at the edge detector would show up as widths that are off by one. The lock boundaries are hit exactly at 14, 15, 25 and 26 samples. A design using inclusive or exclusive compares the wrong way round would lock on an error of 15 or drop lock on 25. A mid-band cycle is placed inside a run of good cycles: a detector that does not restart its run would lock two cycles early. A coincident-edge cycle checks that a zero error is counted rather than skipped, and a large lag checks that a feedback-first cycle can unlock.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        PD_IDLE     = 2'd0,
        PD_LEAD     = 2'd1,
        PD_LAG      = 2'd2,
        PD_BACKLASH = 2'd3
    } pfd_state_t;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_t;

    function automatic int ticks_ceil(input int span_ps, input int period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/pd_edge_detect.sv
module pd_edge_detect #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] level,
    output logic [LANES-1:0] rise
);
    logic [LANES-1:0] level_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) level_q[g] <= 1'b0;
            else        level_q[g] <= level[g];
        end
        assign rise[g] = level[g] & ~level_q[g];
    end
endmodule

// File: rtl/pd_pfd_core.sv
module pd_pfd_core
    import pd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ABL_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output logic             up,
    output logic             dn,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_err
);
    localparam int ABL_W = (ABL_TICKS > 1) ? $clog2(ABL_TICKS) : 1;
    localparam logic [ABL_W-1:0] ABL_LAST = ABL_W'(ABL_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    pfd_state_t       state, state_nx;
    logic [CNT_W-1:0] gap_cnt, gap_cnt_nx;
    logic [ABL_W-1:0] abl_cnt, abl_cnt_nx;
    logic             mv_nx;
    logic [CNT_W-1:0] me_nx;
    logic [CNT_W-1:0] gap_inc;

    assign gap_inc = (gap_cnt == CNT_SAT) ? gap_cnt : gap_cnt + CNT_ONE;

    always_comb begin
        state_nx   = state;
        gap_cnt_nx = gap_cnt;
        abl_cnt_nx = abl_cnt;
        mv_nx      = 1'b0;
        me_nx      = '0;
        unique case (state)
            PD_IDLE: begin
                abl_cnt_nx = '0;
                if (ref_rise && fb_rise) begin
                    state_nx = PD_BACKLASH;
                    mv_nx    = 1'b1;
                    me_nx    = '0;
                end else if (ref_rise) begin
                    state_nx   = PD_LEAD;
                    gap_cnt_nx = CNT_ONE;
                end else if (fb_rise) begin
                    state_nx   = PD_LAG;
                    gap_cnt_nx = CNT_ONE;
                end
            end
            PD_LEAD: begin
                if (fb_rise) begin
                    state_nx   = PD_BACKLASH;
                    abl_cnt_nx = '0;
                    mv_nx      = 1'b1;
                    me_nx      = gap_cnt;
                end else begin
                    gap_cnt_nx = gap_inc;
                end
            end
            PD_LAG: begin
                if (ref_rise) begin
                    state_nx   = PD_BACKLASH;
                    abl_cnt_nx = '0;
                    mv_nx      = 1'b1;
                    me_nx      = gap_cnt;
                end else begin
                    gap_cnt_nx = gap_inc;
                end
            end
            PD_BACKLASH: begin
                if (abl_cnt == ABL_LAST) begin
                    state_nx   = PD_IDLE;
                    abl_cnt_nx = '0;
                end else begin
                    abl_cnt_nx = abl_cnt + 1'b1;
                end
            end
            default: state_nx = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PD_IDLE;
            gap_cnt    <= '0;
            abl_cnt    <= '0;
            meas_valid <= 1'b0;
            meas_err   <= '0;
        end else begin
            state      <= state_nx;
            gap_cnt    <= gap_cnt_nx;
            abl_cnt    <= abl_cnt_nx;
            meas_valid <= mv_nx;
            meas_err   <= me_nx;
        end
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state)
            PD_IDLE:     begin up = 1'b0; dn = 1'b0; end
            PD_LEAD:     begin up = 1'b1; dn = 1'b0; end
            PD_LAG:      begin up = 1'b0; dn = 1'b1; end
            PD_BACKLASH: begin up = 1'b1; dn = 1'b1; end
            default:     begin up = 1'b0; dn = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pd_lock_detect.sv
module pd_lock_detect
    import pd_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LOCK_TICKS   = 15,
    parameter int UNLOCK_TICKS = 25,
    parameter int LOCK_CYCLES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_err,
    output logic             locked
);
    localparam int RUN_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] GOOD_TH = CNT_W'(LOCK_TICKS);
    localparam logic [CNT_W-1:0] BAD_TH  = CNT_W'(UNLOCK_TICKS);
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(LOCK_CYCLES - 1);

    lock_state_t      state, state_nx;
    logic [RUN_W-1:0] run, run_nx;
    logic             is_good, is_bad;

    assign is_good = meas_err < GOOD_TH;
    assign is_bad  = meas_err > BAD_TH;

    always_comb begin
        state_nx = state;
        run_nx   = run;
        unique case (state)
            LK_SEARCH: begin
                if (meas_valid) begin
                    if (!is_good) begin
                        run_nx = '0;
                    end else if (run == RUN_END) begin
                        state_nx = LK_LOCKED;
                        run_nx   = '0;
                    end else begin
                        run_nx = run + 1'b1;
                    end
                end
            end
            LK_LOCKED: begin
                if (meas_valid && is_bad) begin
                    state_nx = LK_SEARCH;
                    run_nx   = '0;
                end
            end
            default: state_nx = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_SEARCH;
            run   <= '0;
        end else begin
            state <= state_nx;
            run   <= run_nx;
        end
    end

    always_comb begin
        unique case (state)
            LK_LOCKED: locked = 1'b1;
            default:   locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/pd_lockdet_top.sv
module pd_lockdet_top
    import pd_pkg::*;
#(
    parameter int SAMPLE_PS   = 1000,
    parameter int ABL_PS      = 3000,
    parameter int LOCK_NS     = 15,
    parameter int UNLOCK_NS   = 25,
    parameter int LOCK_CYCLES = 3,
    parameter int ERR_MAX     = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic up,
    output logic dn,
    output logic locked
);
    localparam int CNT_W        = $clog2(ERR_MAX + 1);
    localparam int ABL_TICKS    = ticks_ceil(ABL_PS, SAMPLE_PS);
    localparam int LOCK_TICKS   = LOCK_NS * 1000 / SAMPLE_PS;
    localparam int UNLOCK_TICKS = UNLOCK_NS * 1000 / SAMPLE_PS;

    logic [1:0]       rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_err;

    pd_edge_detect #(.LANES(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({fb_in, ref_in}),
        .rise  (rise)
    );

    pd_pfd_core #(.CNT_W(CNT_W), .ABL_TICKS(ABL_TICKS)) u_pfd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise   (rise[0]),
        .fb_rise    (rise[1]),
        .up         (up),
        .dn         (dn),
        .meas_valid (meas_valid),
        .meas_err   (meas_err)
    );

    pd_lock_detect #(
        .CNT_W        (CNT_W),
        .LOCK_TICKS   (LOCK_TICKS),
        .UNLOCK_TICKS (UNLOCK_TICKS),
        .LOCK_CYCLES  (LOCK_CYCLES)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_err   (meas_err),
        .locked     (locked)
    );
endmodule

// File: rtl/pd_lockdet_chk.sv
module pd_lockdet_chk #(
    parameter int CNT_W        = 8,
    parameter int LOCK_TICKS   = 15,
    parameter int UNLOCK_TICKS = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up,
    input logic             dn,
    input logic             locked,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_err
);
    localparam logic [CNT_W-1:0] GOOD_TH = CNT_W'(LOCK_TICKS);
    localparam logic [CNT_W-1:0] BAD_TH  = CNT_W'(UNLOCK_TICKS);

    assert_lead_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn) |=> up);

    assert_lag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up) |=> dn);

    assert_up_falls_with_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up) |-> $past(dn));

    assert_dn_falls_with_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn) |-> $past(up));

    assert_lock_rise_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid && (meas_err < GOOD_TH)));

    assert_mid_band_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && (meas_err >= GOOD_TH) && (meas_err <= BAD_TH)) |=> $stable(locked));

    assert_lock_fall_on_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(meas_valid && (meas_err > BAD_TH)));
endmodule

bind pd_lockdet_top pd_lockdet_chk #(
    .CNT_W        (CNT_W),
    .LOCK_TICKS   (LOCK_TICKS),
    .UNLOCK_TICKS (UNLOCK_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up         (up),
    .dn         (dn),
    .locked     (locked),
    .meas_valid (meas_valid),
    .meas_err   (meas_err)
);

// File: tb/tb_pd_lockdet_top.sv
`timescale 1ns/1ps
module tb_pd_lockdet_top;
    localparam int ABL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up, dn, locked;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int    up_w;
        int    dn_w;
        logic  lock;
        string tag;
    } exp_t;

    exp_t sbq[$];

    int   mdl_run = 0;
    logic mdl_lock = 1'b0;

    always #10 clk = ~clk;

    pd_lockdet_top dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .up     (up),
        .dn     (dn),
        .locked (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // d > 0: reference leads by d samples; d < 0: feedback leads; 0: coincident
    task automatic run_cycle(input int d, input string tag);
        exp_t e;
        int   mag;
        mag = (d < 0) ? -d : d;
        if (mag < 15) begin
            mdl_run++;
            if (mdl_run >= 3) begin mdl_lock = 1'b1; mdl_run = 0; end
        end else if (mag > 25) begin
            mdl_lock = 1'b0;
            mdl_run = 0;
        end else begin
            mdl_run = 0;
        end
        if (mdl_lock && mag < 15) mdl_run = 0;
        e.up_w = (d > 0) ? d + ABL : ABL;
        e.dn_w = (d < 0) ? mag + ABL : ABL;
        e.lock = mdl_lock;
        e.tag  = tag;
        sbq.push_back(e);
        @(negedge clk);
        if (d == 0) begin
            ref_in = 1'b1; fb_in = 1'b1;
        end else begin
            if (d > 0) ref_in = 1'b1; else fb_in = 1'b1;
            repeat (mag) @(negedge clk);
            if (d > 0) fb_in = 1'b1; else ref_in = 1'b1;
        end
        repeat (6) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // monitor: measure each pulse pair and compare with the scoreboard head
    int   up_cnt = 0, dn_cnt = 0;
    logic active = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (up || dn) begin
                active = 1'b1;
                if (up) up_cnt++;
                if (dn) dn_cnt++;
            end else if (active) begin
                if (sbq.size() == 0) begin
                    check("R2 unexpected pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check({e.tag, " up width R2 R4"}, up_cnt, e.up_w);
                    check({e.tag, " dn width R3 R4"}, dn_cnt, e.dn_w);
                    check({e.tag, " locked R6 R7 R8"}, int'(locked), int'(e.lock));
                end
                active = 1'b0;
                up_cnt = 0;
                dn_cnt = 0;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 up in reset", int'(up), 0);
        check("R1 dn in reset", int'(dn), 0);
        check("R1 locked in reset", int'(locked), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 up after reset", int'(up), 0);
        check("R1 locked after reset", int'(locked), 0);

        run_cycle(2,   "R2 lead2");
        run_cycle(-3,  "R3 lag3");
        run_cycle(0,   "R5 coincident");         // third good -> lock (R6)
        run_cycle(20,  "R7 mid lead20");          // stays locked
        run_cycle(25,  "R7 boundary25");          // stays locked
        run_cycle(26,  "R8 lead26");              // drops
        run_cycle(1,   "R6 good1");
        run_cycle(14,  "R6 boundary14");
        run_cycle(15,  "R7 boundary15 restart");  // restarts run
        run_cycle(-5,  "R6 good");
        run_cycle(7,   "R6 good");
        run_cycle(0,   "R6 third good");          // lock
        run_cycle(-30, "R8 lag30");               // drops
        run_cycle(-1,  "R3 lag1");
        run_cycle(40,  "R2 lead40 while unlocked");
        run_cycle(3,   "R6 good");
        run_cycle(4,   "R6 good");
        run_cycle(-14, "R6 third good");          // lock
        repeat (5) @(negedge clk);
        check("R4 scoreboard drained", sbq.size(), 0);
        check("R4 idle up low", int'(up), 0);
        check("R4 idle dn low", int'(dn), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule